// File: doc/BRIEF.md
# Duty-Cycled Radio Mode Sequencer

This block decides what the radio front end of a packet transceiver is allowed to do at any moment. It has four modes: idle, host transfer, transmit and receive. In idle it listens for a preamble. When power saving is enabled, idle becomes a duty cycle. The receiver is switched on for a fixed listening window. If nothing is heard in that window, the receiver is switched off for a programmable sleep span, and the cycle then repeats.

An active-low request from the host ends idle at once, from either phase of the cycle. The block then enters a host transfer, during which the whole transceiver is held off. At the end of a host download the block transmits. A valid received packet leads to a host upload and then back to idle.

A slow timing strobe drives both timers. It pulses once every 0.5 ms, so the default listening window of 5 strobes lasts 2.5 ms. The legal sleep span of 44 to 362 strobes covers 22 ms to 181 ms. The block also flags when a transmission must carry the long preamble, which is needed because the far end is itself duty-cycling.

Top module: `rsq_radio_ctrl`

## Requirements
- R1: After reset the mode output reads idle (encoding 0) with the receiver enabled. The transmitter, the transceiver-off flag and the dozing flag are all low. The mode encoding is idle=0, host transfer=1, transmit=2, receive=3.
- R2: While power saving is disabled, idle keeps the receiver enabled on every cycle and the dozing flag stays low.
- R3: With power saving enabled, each listening window lasts exactly TICK_ON strobes (default 5). Timing starts with the receiver on when power saving is switched on or when idle is re-entered. When the window ends with no preamble, the receiver turns off and the dozing flag goes high.
- R4: Each sleep span lasts the programmed strobe count, clamped to OFF_MIN..OFF_MAX (default 44..362). After the span the next listening window begins.
- R5: A low transmit request seen in idle, whether listening or dozing, moves the block to host transfer on the next clock edge.
- R6: A host transfer that began from a transmit request ends on the host-done pulse and enters transmit. Transmit holds until the transmit-done pulse and then returns to idle.
- R7: A preamble flag seen while the receiver is listening in idle moves the block to receive on the next edge. The same flag seen while dozing is ignored.
- R8: Receive ends on the receive-done pulse. A valid packet leads to a host upload transfer, and host-done then returns the block to idle rather than to transmit. An invalid packet returns the block straight to idle.
- R9: The receiver and transmitter are never enabled together. During a host transfer both are disabled and the transceiver-off flag is high.
- R10: During transmit, the long-preamble flag equals the peer-sleeping input sampled on the edge that accepted host-done. The flag is held for the whole transmission.
- R11: Returning to idle from any other mode restarts a full listening window.
- R12: When a transmit request and a preamble flag arrive in the same idle cycle, the transmit request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timing strobe (0.5 ms nominal) |
| ps_en | input | 1 | Power-saving duty cycle enable |
| off_ticks | input | OFF_W | Requested sleep span in strobes, clamped internally |
| tx_req_n | input | 1 | Active-low host transmit request |
| pre_det | input | 1 | Preamble detected by the receiver |
| rx_done | input | 1 | Reception finished pulse |
| rx_ok | input | 1 | Received packet passed its check (valid with rx_done) |
| tx_done | input | 1 | Transmission finished pulse |
| host_done | input | 1 | Host transfer finished pulse |
| peer_sleeps | input | 1 | Far end is in power-save mode |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| xcvr_off | output | 1 | Transceiver disabled for a host transfer |
| dozing | output | 1 | Idle with receiver off in the sleep span |
| long_pre | output | 1 | Use the extended preamble for this transmission |
| mode | output | 2 | Current mode (0 idle, 1 host, 2 transmit, 3 receive) |

## Verification
On every cycle the checker confirms several properties. The receiver and transmitter are never both on, and a host transfer silences both. A request or a heard preamble in idle always leads to the right next mode. Transmit never ends without its done pulse, and a failed reception goes back to idle. The long-preamble flag matches the peer state and stays stable. Strobe counters bound both the listening window and the sleep span.

Three behaviours can only be shown by the bench scenarios:
- the exact window and span lengths, including the clamping at both ends of the range;
- the restart of a full window after each return to idle;
- the difference between a host upload and a host download.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_HOST = 2'd1,
        MODE_TX   = 2'd2,
        MODE_RX   = 2'd3
    } mode_e;

    // Registered sequencer state: mode, upload direction, preamble choice.
    typedef struct packed {
        mode_e mode;
        logic  upload;
        logic  long_pre;
    } seq_state_t;

    localparam int unsigned DEF_TICK_ON = 5;
    localparam int unsigned DEF_OFF_MIN = 44;
    localparam int unsigned DEF_OFF_MAX = 362;

    function automatic int unsigned clamp_u(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/rsq_sleep_timer.sv
module rsq_sleep_timer #(
    parameter int unsigned TICK_ON = rsq_pkg::DEF_TICK_ON,
    parameter int unsigned OFF_MIN = rsq_pkg::DEF_OFF_MIN,
    parameter int unsigned OFF_MAX = rsq_pkg::DEF_OFF_MAX,
    parameter int unsigned OFF_W   = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             ps_en,
    input  logic             tick,
    input  logic [OFF_W-1:0] off_ticks,
    output logic             listen,
    output logic             sleeping
);
    localparam int unsigned LIM = (OFF_MAX > TICK_ON) ? OFF_MAX : TICK_ON;
    localparam int unsigned CW  = $clog2(LIM + 1);

    logic          off_ph;
    logic [CW-1:0] cnt;
    logic [CW-1:0] off_lim;
    logic          on_last;
    logic          off_last;

    assign off_lim  = CW'(rsq_pkg::clamp_u(32'(off_ticks), OFF_MIN, OFF_MAX));
    assign on_last  = (cnt >= CW'(TICK_ON - 1));
    assign off_last = (cnt >= off_lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !active || !ps_en) begin
            off_ph <= 1'b0;
            cnt    <= '0;
        end else if (tick) begin
            if ((!off_ph && on_last) || (off_ph && off_last)) begin
                off_ph <= !off_ph;
                cnt    <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign listen   = !ps_en || !off_ph;
    assign sleeping = ps_en && off_ph;
endmodule

// File: rtl/rsq_mode_fsm.sv
module rsq_mode_fsm (
    input  logic          clk,
    input  logic          rst,
    input  logic          listen,
    input  logic          tx_req_n,
    input  logic          pre_det,
    input  logic          rx_done,
    input  logic          rx_ok,
    input  logic          tx_done,
    input  logic          host_done,
    input  logic          peer_sleeps,
    output rsq_pkg::mode_e mode,
    output logic          long_pre_q
);
    import rsq_pkg::*;

    seq_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (cur.mode)
            MODE_IDLE: begin
                if (!tx_req_n) begin
                    nxt.mode   = MODE_HOST;
                    nxt.upload = 1'b0;
                end else if (listen && pre_det) begin
                    nxt.mode = MODE_RX;
                end
            end
            MODE_HOST: begin
                if (host_done) begin
                    if (cur.upload) begin
                        nxt.mode = MODE_IDLE;
                    end else begin
                        nxt.mode     = MODE_TX;
                        nxt.long_pre = peer_sleeps;
                    end
                end
            end
            MODE_TX: begin
                if (tx_done) begin
                    nxt.mode     = MODE_IDLE;
                    nxt.long_pre = 1'b0;
                end
            end
            MODE_RX: begin
                if (rx_done) begin
                    nxt.mode   = rx_ok ? MODE_HOST : MODE_IDLE;
                    nxt.upload = rx_ok;
                end
            end
            default: nxt.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{mode: MODE_IDLE, upload: 1'b0, long_pre: 1'b0};
        end else begin
            cur <= nxt;
        end
    end

    assign mode       = cur.mode;
    assign long_pre_q = cur.long_pre;
endmodule

// File: rtl/rsq_radio_ctrl.sv
module rsq_radio_ctrl #(
    parameter int unsigned TICK_ON = rsq_pkg::DEF_TICK_ON,
    parameter int unsigned OFF_MIN = rsq_pkg::DEF_OFF_MIN,
    parameter int unsigned OFF_MAX = rsq_pkg::DEF_OFF_MAX,
    parameter int unsigned OFF_W   = $clog2(OFF_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ps_en,
    input  logic [OFF_W-1:0] off_ticks,
    input  logic             tx_req_n,
    input  logic             pre_det,
    input  logic             rx_done,
    input  logic             rx_ok,
    input  logic             tx_done,
    input  logic             host_done,
    input  logic             peer_sleeps,
    output logic             rx_en,
    output logic             tx_en,
    output logic             xcvr_off,
    output logic             dozing,
    output logic             long_pre,
    output logic [1:0]       mode
);
    import rsq_pkg::*;

    mode_e cur_mode;
    logic  in_idle;
    logic  listen;
    logic  sleeping;
    logic  lp_q;

    assign in_idle = (cur_mode == MODE_IDLE);

    rsq_sleep_timer #(
        .TICK_ON (TICK_ON),
        .OFF_MIN (OFF_MIN),
        .OFF_MAX (OFF_MAX),
        .OFF_W   (OFF_W)
    ) timer_i (
        .clk       (clk),
        .rst       (rst),
        .active    (in_idle),
        .ps_en     (ps_en),
        .tick      (tick),
        .off_ticks (off_ticks),
        .listen    (listen),
        .sleeping  (sleeping)
    );

    rsq_mode_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .listen      (listen),
        .tx_req_n    (tx_req_n),
        .pre_det     (pre_det),
        .rx_done     (rx_done),
        .rx_ok       (rx_ok),
        .tx_done     (tx_done),
        .host_done   (host_done),
        .peer_sleeps (peer_sleeps),
        .mode        (cur_mode),
        .long_pre_q  (lp_q)
    );

    assign rx_en    = (in_idle && listen) || (cur_mode == MODE_RX);
    assign tx_en    = (cur_mode == MODE_TX);
    assign xcvr_off = (cur_mode == MODE_HOST);
    assign dozing   = in_idle && sleeping;
    assign long_pre = tx_en && lp_q;
    assign mode     = cur_mode;
endmodule

// File: rtl/rsq_radio_ctrl_chk.sv
module rsq_radio_ctrl_chk #(
    parameter int unsigned TICK_ON = rsq_pkg::DEF_TICK_ON,
    parameter int unsigned OFF_MAX = rsq_pkg::DEF_OFF_MAX
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       ps_en,
    input logic       tx_req_n,
    input logic       pre_det,
    input logic       rx_done,
    input logic       rx_ok,
    input logic       tx_done,
    input logic       host_done,
    input logic       peer_sleeps,
    input logic       rx_en,
    input logic       tx_en,
    input logic       xcvr_off,
    input logic       dozing,
    input logic       long_pre,
    input logic [1:0] mode
);
    localparam int unsigned CW = $clog2(OFF_MAX + TICK_ON + 2);

    logic [CW-1:0] on_tk;
    logic [CW-1:0] off_tk;
    logic          win;

    assign win = (mode == 2'd0) && ps_en && !dozing;

    always_ff @(posedge clk) begin
        if (rst || !win)   on_tk <= '0;
        else if (tick)     on_tk <= on_tk + CW'(1);
        if (rst || !dozing) off_tk <= '0;
        else if (tick)      off_tk <= off_tk + CW'(1);
    end

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(rx_en && tx_en));
    assert_host_silent_R9: assert property (@(posedge clk) disable iff (rst)
        xcvr_off |-> (!rx_en && !tx_en));
    assert_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !tx_req_n) |=> (mode == 2'd1));
    assert_hear_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && rx_en && pre_det && tx_req_n) |=> (mode == 2'd3));
    assert_deaf_R7: assert property (@(posedge clk) disable iff (rst)
        (dozing && tx_req_n) |=> (mode == 2'd0));
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !tx_done) |=> (mode == 2'd2));
    assert_rx_bad_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && rx_done && !rx_ok) |=> (mode == 2'd0));
    assert_no_doze_R2: assert property (@(posedge clk) disable iff (rst)
        (!ps_en && mode == 2'd0) |-> (rx_en && !dozing));
    assert_pre_pick_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> (long_pre == $past(peer_sleeps)));
    assert_pre_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en)) |-> $stable(long_pre));
    assert_window_R3: assert property (@(posedge clk) disable iff (rst)
        on_tk <= CW'(TICK_ON));
    assert_span_R4: assert property (@(posedge clk) disable iff (rst)
        off_tk <= CW'(OFF_MAX));
endmodule

bind rsq_radio_ctrl rsq_radio_ctrl_chk #(
    .TICK_ON (TICK_ON),
    .OFF_MAX (OFF_MAX)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .ps_en       (ps_en),
    .tx_req_n    (tx_req_n),
    .pre_det     (pre_det),
    .rx_done     (rx_done),
    .rx_ok       (rx_ok),
    .tx_done     (tx_done),
    .host_done   (host_done),
    .peer_sleeps (peer_sleeps),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .xcvr_off    (xcvr_off),
    .dozing      (dozing),
    .long_pre    (long_pre),
    .mode        (mode)
);

// File: tb/rsq_radio_ctrl_tb_top.sv
`timescale 1ns/1ps
module rsq_radio_ctrl_tb_top;
    localparam int ON_T   = 5;
    localparam int OMIN   = 44;
    localparam int OMAX   = 362;
    localparam int OW     = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, ps_en = 1'b0, tx_req_n = 1'b1, pre_det = 1'b0;
    logic rx_done = 1'b0, rx_ok = 1'b0, tx_done = 1'b0, host_done = 1'b0;
    logic peer_sleeps = 1'b0;
    logic [OW-1:0] off_ticks = '0;
    logic rx_en, tx_en, xcvr_off, dozing, long_pre;
    logic [1:0] mode;

    int n_cmp = 0, n_bad = 0, both_on = 0, cyc = 0;
    int tick_per = 1, tick_ph = 0;
    bit last_tick = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    rsq_radio_ctrl dut_i (
        .clk(clk), .rst(rst), .tick(tick), .ps_en(ps_en), .off_ticks(off_ticks),
        .tx_req_n(tx_req_n), .pre_det(pre_det), .rx_done(rx_done), .rx_ok(rx_ok),
        .tx_done(tx_done), .host_done(host_done), .peer_sleeps(peer_sleeps),
        .rx_en(rx_en), .tx_en(tx_en), .xcvr_off(xcvr_off), .dozing(dozing),
        .long_pre(long_pre), .mode(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        tick = ((tick_ph % tick_per) == 0);
        last_tick = tick;
        @(posedge clk);
        #1;
        tick_ph++;
        if (rx_en && tx_en) both_on++;
    endtask

    task automatic run_len(input bit want, output int ticks);
        int guard = 0;
        ticks = 0;
        while (rx_en == want && guard < 20000) begin
            step();
            if (last_tick) ticks++;
            guard++;
        end
    endtask

    function automatic int clampv(input int v);
        return (v < OMIN) ? OMIN : (v > OMAX) ? OMAX : v;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    initial begin
        int t;
        int vals[9] = '{0, 43, 44, 45, 200, 361, 362, 363, 511};
        int low_cnt;
        repeat (3) step();
        rst = 1'b0;
        #0;
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 rx_en", rx_en, 1);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 xcvr_off", xcvr_off, 0);
        chk("R1 dozing", dozing, 0);

        // R2 power saving off: receiver stays on
        low_cnt = 0;
        for (int i = 0; i < 800; i++) begin
            step();
            if (!rx_en || dozing) low_cnt++;
        end
        chk("R2 receiver gaps", low_cnt, 0);

        // R3/R4 sweep of sleep span, including clamping
        foreach (vals[k]) begin
            off_ticks = OW'(vals[k]);
            ps_en = 1'b0; step(); ps_en = 1'b1;
            run_len(1'b1, t);
            chk("R3 window ticks", t, ON_T);
            chk("R3 dozing", dozing, 1);
            run_len(1'b0, t);
            chk("R4 span ticks", t, clampv(vals[k]));
            run_len(1'b1, t);
            chk("R3 next window ticks", t, ON_T);
        end

        // R3/R4 with sparse strobes
        tick_per = 3; tick_ph = 1;
        off_ticks = OW'(50);
        ps_en = 1'b0; step(); ps_en = 1'b1;
        run_len(1'b1, t);
        chk("R3 sparse window", t, ON_T);
        run_len(1'b0, t);
        chk("R4 sparse span", t, 50);
        tick_per = 1;

        // R5 wake from dozing
        off_ticks = OW'(100);
        ps_en = 1'b0; step(); ps_en = 1'b1;
        run_len(1'b1, t);
        chk("R5 dozing before", dozing, 1);
        tx_req_n = 1'b0; step(); tx_req_n = 1'b1;
        chk("R5 mode host", mode, 1);
        chk("R9 xcvr_off", xcvr_off, 1);
        chk("R9 rx off in host", rx_en, 0);
        repeat (3) step();
        chk("R6 host holds", mode, 1);
        peer_sleeps = 1'b1; host_done = 1'b1; step(); host_done = 1'b0;
        peer_sleeps = 1'b0;
        chk("R6 mode tx", mode, 2);
        chk("R6 tx_en", tx_en, 1);
        chk("R10 long preamble", long_pre, 1);
        repeat (4) step();
        chk("R6 tx holds", tx_en, 1);
        chk("R10 long preamble held", long_pre, 1);
        tx_done = 1'b1; step(); tx_done = 1'b0;
        chk("R6 back to idle", mode, 0);
        run_len(1'b1, t);
        chk("R11 full window after tx", t, ON_T);

        // R7 preamble ignored while dozing
        chk("R7 dozing", dozing, 1);
        pre_det = 1'b1; step(); pre_det = 1'b0;
        chk("R7 ignored while dozing", mode, 0);

        // R7 / R8 receive paths
        ps_en = 1'b0; step();
        pre_det = 1'b1; step(); pre_det = 1'b0;
        chk("R7 mode rx", mode, 3);
        chk("R9 rx only", {rx_en, tx_en}, 2);
        rx_ok = 1'b0; rx_done = 1'b1; step(); rx_done = 1'b0;
        chk("R8 bad packet idle", mode, 0);
        pre_det = 1'b1; step(); pre_det = 1'b0;
        rx_ok = 1'b1; rx_done = 1'b1; step(); rx_done = 1'b0; rx_ok = 1'b0;
        chk("R8 good packet host", mode, 1);
        chk("R8 xcvr_off", xcvr_off, 1);
        host_done = 1'b1; step(); host_done = 1'b0;
        chk("R8 upload returns idle", mode, 0);

        // R11 window restart after receive
        ps_en = 1'b1;
        pre_det = 1'b1; step(); pre_det = 1'b0;
        rx_done = 1'b1; step(); rx_done = 1'b0;
        run_len(1'b1, t);
        chk("R11 full window after rx", t, ON_T);

        // R12 request beats preamble
        ps_en = 1'b0; step();
        tx_req_n = 1'b0; pre_det = 1'b1; step();
        tx_req_n = 1'b1; pre_det = 1'b0;
        chk("R12 request wins", mode, 1);
        host_done = 1'b1; step(); host_done = 1'b0;
        chk("R10 normal preamble", long_pre, 0);
        chk("R10 in tx", mode, 2);
        tx_done = 1'b1; step(); tx_done = 1'b0;
        chk("R6 idle again", mode, 0);

        chk("R9 never both on", both_on, 0);
        done = 1'b1;
        summary();
    end
endmodule